// File: doc/BRIEF.md
# Duplex Roll-Forward Recovery Controller

This controller supervises a pair of modules that execute the same work in lockstep, plus a third module held in reserve with its power off. At every checkpoint it compares the state signatures of the two active members. While they agree, nothing else happens. When they disagree, the reserve module is powered and loaded with the state saved at the previous checkpoint, and it re-executes the interval in which the disagreement arose. Meanwhile the pair keeps running into the next interval. The re-executed signature then arbitrates. The member that differs from it is judged faulty and is overwritten with the good member's state, and the reserve is powered down again.

A member that is found faulty twice without enough clean checkpoints in between is treated as permanently failed. The reserve then takes its place for good. If the reserve agrees with neither member, the controller requests a rollback to the last good checkpoint. An optional confirmation mode keeps the reserve running for one more interval and checks it against member A before releasing it. Compute logic, state transfer and checkpoint storage live outside the block. The controller only sees signatures with strobes and issues commands that are acknowledged by a done handshake.

Top module: `rfc_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every command output, powers the reserve down and sets the status to 0 (duplex). It also clears both fault counts, so the first later fault of either member is repaired as transient.
- R2: A checkpoint at which the A and B signatures are equal leaves the reserve unpowered, issues no command and keeps the status at 0.
- R3: A checkpoint with unequal A and B signatures powers the reserve and gives a one-cycle load pulse in the next cycle, and the status becomes 1 (recovering).
- R4: When the reserve's re-executed signature equals the saved A signature, copy A-to-B is issued. When it equals the saved B signature, copy B-to-A is issued. The command is held until the done handshake, and at most one command output is high in any cycle.
- R5: With confirmation off, the cycle after the done handshake shows the reserve unpowered and the status at 0.
- R6: With confirmation on, the reserve stays powered with status 1 after the copy completes. At the next checkpoint it is released, with status 0 if its signature equals A's, or with a rollback if it does not.
- R7: A re-executed signature that matches neither saved signature gives a one-cycle rollback pulse with status 3 and the reserve unpowered, and the status is 0 in the following cycle.
- R8: A fault in a member whose fault count is already non-zero issues a swap command for that member instead of a copy. The swap is held until done, and afterwards the status stays at 2 (spared) with the reserve powered.
- R9: After CLEAN_LIMIT consecutive matching checkpoints in duplex mode, both fault counts clear. With one fewer, the count of a faulted member survives.
- R10: A checkpoint that arrives while a copy or swap awaits done is kept pending and is evaluated once the controller is back in a state that evaluates checkpoints.
- R11: In spared mode each checkpoint compares the surviving member with the reserve. A difference gives a one-cycle rollback pulse with status 3, after which the status returns to 2.
- R12: Each signature is captured on its own valid strobe, and a checkpoint without a strobe uses the last captured value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ckpt | input | 1 | Checkpoint pulse |
| confirm_en | input | 1 | Keep the reserve for one confirming interval |
| sig_a | input | SIG_W | Member A state signature |
| sig_a_vld | input | 1 | Strobe for sig_a |
| sig_b | input | SIG_W | Member B state signature |
| sig_b_vld | input | 1 | Strobe for sig_b |
| sig_s | input | SIG_W | Reserve module signature |
| sig_s_vld | input | 1 | Strobe for sig_s; after a load it marks the re-executed result |
| xfer_done | input | 1 | Done handshake for copy and swap commands |
| spare_en | output | 1 | Reserve power enable |
| spare_load | output | 1 | Load the reserve from the previous checkpoint (pulse) |
| copy_a2b | output | 1 | Copy A's state over B |
| copy_b2a | output | 1 | Copy B's state over A |
| swap_a | output | 1 | Replace A with the reserve permanently |
| swap_b | output | 1 | Replace B with the reserve permanently |
| rollback | output | 1 | Roll back to the last good checkpoint (pulse) |
| mode_stat | output | 2 | 0 duplex, 1 recovering, 2 spared, 3 rollback issued |

## Verification
The bench builds the controller with CLEAN_LIMIT set to 3, so the counter-clearing boundary of R9 can be reached in a few checkpoints. Both sides of that boundary (2 and 3 clean checkpoints) are covered in directed runs, and random episodes cross it often. SIG_W stays at 32, so single-bit signature differences at any position can be produced.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  typedef enum logic [2:0] {
    ST_DUPLEX,
    ST_RERUN,
    ST_REPAIR,
    ST_CONFIRM,
    ST_SWAP,
    ST_SPARED
  } rfc_state_e;

  localparam logic [1:0] STAT_DUPLEX  = 2'd0;
  localparam logic [1:0] STAT_RECOVER = 2'd1;
  localparam logic [1:0] STAT_SPARED  = 2'd2;
  localparam logic [1:0] STAT_ROLLBK  = 2'd3;

  localparam int NSIG = 3;
  localparam int IDX_A = 0;
  localparam int IDX_B = 1;
  localparam int IDX_S = 2;
endpackage

// File: rtl/rfc_sig_hold.sv
module rfc_sig_hold #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         vld,
  input  logic [W-1:0] sig_in,
  output logic [W-1:0] sig_cur
);
  logic [W-1:0] held;

  always_ff @(posedge clk) begin
    if (rst) held <= '0;
    else if (vld) held <= sig_in;
  end

  // a strobe in the checkpoint cycle wins over the stored copy
  assign sig_cur = vld ? sig_in : held;
endmodule

// File: rtl/rfc_fault_tracker.sv
module rfc_fault_tracker #(
  parameter int CLEAN_LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clean_evt,
  input  logic dirty_evt,
  input  logic fault_evt,
  input  logic fault_on_b,
  output logic repeat_hit
);
  localparam int CW = (CLEAN_LIMIT < 2) ? 1 : $clog2(CLEAN_LIMIT + 1);
  localparam logic [CW-1:0] CLEAN_LAST = CW'(CLEAN_LIMIT - 1);

  logic [1:0]    fcnt [2];
  logic [CW-1:0] clean_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int m = 0; m < 2; m++) fcnt[m] <= 2'd0;
      clean_run <= '0;
    end else if (fault_evt) begin
      clean_run <= '0;
      if (fcnt[fault_on_b] != 2'd3) fcnt[fault_on_b] <= fcnt[fault_on_b] + 2'd1;
    end else if (dirty_evt) begin
      clean_run <= '0;
    end else if (clean_evt) begin
      if (clean_run == CLEAN_LAST) begin
        clean_run <= '0;
        for (int m = 0; m < 2; m++) fcnt[m] <= 2'd0;
      end else begin
        clean_run <= clean_run + 1'b1;
      end
    end
  end

  // the count reaches two on this fault when it is already non-zero
  assign repeat_hit = (fcnt[fault_on_b] != 2'd0);
endmodule

// File: rtl/rfc_ctrl.sv
module rfc_ctrl
  import rfc_pkg::*;
#(
  parameter int SIG_W       = 32,
  parameter int CLEAN_LIMIT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ckpt,
  input  logic             confirm_en,
  input  logic [SIG_W-1:0] sig_a,
  input  logic             sig_a_vld,
  input  logic [SIG_W-1:0] sig_b,
  input  logic             sig_b_vld,
  input  logic [SIG_W-1:0] sig_s,
  input  logic             sig_s_vld,
  input  logic             xfer_done,
  output logic             spare_en,
  output logic             spare_load,
  output logic             copy_a2b,
  output logic             copy_b2a,
  output logic             swap_a,
  output logic             swap_b,
  output logic             rollback,
  output logic [1:0]       mode_stat
);
  logic [SIG_W-1:0] raw_sig [NSIG];
  logic [SIG_W-1:0] cur_sig [NSIG];
  logic [NSIG-1:0]  raw_vld;

  assign raw_sig[IDX_A] = sig_a;
  assign raw_sig[IDX_B] = sig_b;
  assign raw_sig[IDX_S] = sig_s;
  assign raw_vld = {sig_s_vld, sig_b_vld, sig_a_vld};

  for (genvar g = 0; g < NSIG; g++) begin : g_cap
    rfc_sig_hold #(.W(SIG_W)) u_hold (
      .clk     (clk),
      .rst     (rst),
      .vld     (raw_vld[g]),
      .sig_in  (raw_sig[g]),
      .sig_cur (cur_sig[g])
    );
  end

  rfc_state_e       state;
  logic             pend;
  logic             b_replaced;
  logic [SIG_W-1:0] keep_a, keep_b;

  logic             eval_ckpt;
  logic             pair_eq;
  logic             s_says_b_bad, s_says_a_bad;
  logic             repeat_hit;
  logic [SIG_W-1:0] survivor;

  assign eval_ckpt    = ckpt | pend;
  assign pair_eq      = (cur_sig[IDX_A] == cur_sig[IDX_B]);
  assign s_says_b_bad = (sig_s == keep_a);
  assign s_says_a_bad = (sig_s == keep_b);
  assign survivor     = b_replaced ? cur_sig[IDX_A] : cur_sig[IDX_B];

  rfc_fault_tracker #(.CLEAN_LIMIT(CLEAN_LIMIT)) u_track (
    .clk        (clk),
    .rst        (rst),
    .clean_evt  ((state == ST_DUPLEX) && eval_ckpt && pair_eq),
    .dirty_evt  ((state == ST_DUPLEX) && eval_ckpt && !pair_eq),
    .fault_evt  ((state == ST_RERUN) && sig_s_vld && (s_says_a_bad || s_says_b_bad)),
    .fault_on_b (s_says_b_bad),
    .repeat_hit (repeat_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_DUPLEX;
      pend       <= 1'b0;
      b_replaced <= 1'b0;
      keep_a     <= '0;
      keep_b     <= '0;
      spare_en   <= 1'b0;
      spare_load <= 1'b0;
      copy_a2b   <= 1'b0;
      copy_b2a   <= 1'b0;
      swap_a     <= 1'b0;
      swap_b     <= 1'b0;
      rollback   <= 1'b0;
      mode_stat  <= STAT_DUPLEX;
    end else begin
      spare_load <= 1'b0;
      rollback   <= 1'b0;
      case (state)
        ST_DUPLEX: begin
          mode_stat <= STAT_DUPLEX;
          if (eval_ckpt) begin
            pend <= 1'b0;
            if (!pair_eq) begin
              keep_a     <= cur_sig[IDX_A];
              keep_b     <= cur_sig[IDX_B];
              spare_en   <= 1'b1;
              spare_load <= 1'b1;
              mode_stat  <= STAT_RECOVER;
              state      <= ST_RERUN;
            end
          end
        end
        ST_RERUN: begin
          if (sig_s_vld) begin
            if (s_says_b_bad || s_says_a_bad) begin
              if (repeat_hit) begin
                swap_b     <= s_says_b_bad;
                swap_a     <= !s_says_b_bad;
                b_replaced <= s_says_b_bad;
                state      <= ST_SWAP;
              end else begin
                copy_a2b <= s_says_b_bad;
                copy_b2a <= !s_says_b_bad;
                state    <= ST_REPAIR;
              end
            end else begin
              rollback  <= 1'b1;
              spare_en  <= 1'b0;
              mode_stat <= STAT_ROLLBK;
              state     <= ST_DUPLEX;
            end
          end
        end
        ST_REPAIR: begin
          if (ckpt) pend <= 1'b1;
          if (xfer_done) begin
            copy_a2b <= 1'b0;
            copy_b2a <= 1'b0;
            if (confirm_en) begin
              state <= ST_CONFIRM;
            end else begin
              spare_en  <= 1'b0;
              mode_stat <= STAT_DUPLEX;
              state     <= ST_DUPLEX;
            end
          end
        end
        ST_CONFIRM: begin
          if (eval_ckpt) begin
            pend     <= 1'b0;
            spare_en <= 1'b0;
            state    <= ST_DUPLEX;
            if (cur_sig[IDX_S] == cur_sig[IDX_A]) begin
              mode_stat <= STAT_DUPLEX;
            end else begin
              rollback  <= 1'b1;
              mode_stat <= STAT_ROLLBK;
            end
          end
        end
        ST_SWAP: begin
          if (ckpt) pend <= 1'b1;
          if (xfer_done) begin
            swap_a    <= 1'b0;
            swap_b    <= 1'b0;
            mode_stat <= STAT_SPARED;
            state     <= ST_SPARED;
          end
        end
        ST_SPARED: begin
          mode_stat <= STAT_SPARED;
          if (eval_ckpt) begin
            pend <= 1'b0;
            if (survivor != cur_sig[IDX_S]) begin
              rollback  <= 1'b1;
              mode_stat <= STAT_ROLLBK;
            end
          end
        end
        default: state <= ST_DUPLEX;
      endcase
    end
  end
endmodule

// File: rtl/rfc_ctrl_checker.sv
module rfc_ctrl_checker (
  input logic       clk,
  input logic       rst,
  input logic       xfer_done,
  input logic       spare_en,
  input logic       spare_load,
  input logic       copy_a2b,
  input logic       copy_b2a,
  input logic       swap_a,
  input logic       swap_b,
  input logic       rollback,
  input logic [1:0] mode_stat
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (mode_stat == 2'd0 && !spare_en && !rollback && !spare_load));

  p_duplex_cold_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_stat == 2'd0) |-> (!spare_en && !copy_a2b && !copy_b2a && !swap_a && !swap_b));

  p_load_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    spare_load |=> !spare_load);

  p_load_powered_r3: assert property (@(posedge clk) disable iff (rst)
    spare_load |-> spare_en);

  p_cmd_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({spare_load, copy_a2b, copy_b2a, swap_a, swap_b, rollback}));

  p_copy_ab_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (copy_a2b && !xfer_done) |=> copy_a2b);

  p_copy_ba_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (copy_b2a && !xfer_done) |=> copy_b2a);

  p_rollback_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    rollback |=> !rollback);

  p_rollback_status_r7: assert property (@(posedge clk) disable iff (rst)
    rollback |-> (mode_stat == 2'd3));

  p_swap_hold_r8: assert property (@(posedge clk) disable iff (rst)
    ((swap_a || swap_b) && !xfer_done) |=> (swap_a || swap_b));

  p_spared_powered_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_stat == 2'd2) |-> spare_en);

  p_spared_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (mode_stat == 2'd2) |=> (mode_stat == 2'd2 || mode_stat == 2'd3));
endmodule

bind rfc_ctrl rfc_ctrl_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .xfer_done  (xfer_done),
  .spare_en   (spare_en),
  .spare_load (spare_load),
  .copy_a2b   (copy_a2b),
  .copy_b2a   (copy_b2a),
  .swap_a     (swap_a),
  .swap_b     (swap_b),
  .rollback   (rollback),
  .mode_stat  (mode_stat)
);

// File: tb/rfc_ctrl_tb.sv
`timescale 1ns/1ps
module rfc_ctrl_tb;
  localparam int W   = 32;
  localparam int LIM = 3;

  logic         clk = 1'b0;
  logic         rst, ckpt, confirm_en, xfer_done;
  logic [W-1:0] sig_a, sig_b, sig_s;
  logic         sig_a_vld, sig_b_vld, sig_s_vld;
  logic         spare_en, spare_load, copy_a2b, copy_b2a, swap_a, swap_b, rollback;
  logic [1:0]   mode_stat;

  int checks = 0;
  int fails  = 0;
  int m_cnt [2];
  int m_clean;

  always #2.5 clk = ~clk;

  rfc_ctrl #(.SIG_W(W), .CLEAN_LIMIT(LIM)) u_dut (
    .clk(clk), .rst(rst), .ckpt(ckpt), .confirm_en(confirm_en),
    .sig_a(sig_a), .sig_a_vld(sig_a_vld), .sig_b(sig_b), .sig_b_vld(sig_b_vld),
    .sig_s(sig_s), .sig_s_vld(sig_s_vld), .xfer_done(xfer_done),
    .spare_en(spare_en), .spare_load(spare_load), .copy_a2b(copy_a2b),
    .copy_b2a(copy_b2a), .swap_a(swap_a), .swap_b(swap_b),
    .rollback(rollback), .mode_stat(mode_stat)
  );

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    for (int n = 0; n < 100000; n++) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
    $finish;
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bench model of the arbitration rule: 0 = B faulty, 1 = A faulty, 2 = both
  function automatic int arb(logic [W-1:0] ka, logic [W-1:0] kb, logic [W-1:0] s);
    if (s == ka) return 0;
    if (s == kb) return 1;
    return 2;
  endfunction

  function automatic logic [W-1:0] neither(logic [W-1:0] ka, logic [W-1:0] kb);
    logic [W-1:0] c = ka + 1;
    if (c == kb) c = ka + 2;
    return c;
  endfunction

  task automatic do_reset();
    rst = 1'b1; cyc(); cyc(); rst = 1'b0;
    m_cnt[0] = 0; m_cnt[1] = 0; m_clean = 0;
    chk("R1 outputs after reset",
        {spare_en, spare_load, copy_a2b, copy_b2a, swap_a, swap_b, rollback, mode_stat}, 0);
  endtask

  task automatic ckpt_all(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] s, bit with_s);
    sig_a = a; sig_b = b; sig_s = s;
    sig_a_vld = 1'b1; sig_b_vld = 1'b1; sig_s_vld = with_s; ckpt = 1'b1;
    cyc();
    sig_a_vld = 1'b0; sig_b_vld = 1'b0; sig_s_vld = 1'b0; ckpt = 1'b0;
  endtask

  task automatic model_clean();
    m_clean++;
    if (m_clean == LIM) begin m_clean = 0; m_cnt[0] = 0; m_cnt[1] = 0; end
  endtask

  task automatic finish_copy(bit ext, bit agree);
    logic [W-1:0] v;
    xfer_done = 1'b1; cyc(); xfer_done = 1'b0;
    chk("R4 copy released", {copy_a2b, copy_b2a}, 0);
    if (ext) begin
      chk("R6 reserve kept", {spare_en, mode_stat}, {1'b1, 2'd1});
      v = $urandom;
      ckpt_all(v, v, agree ? v : ~v, 1'b1);
      if (agree) chk("R6 confirm agree", {spare_en, rollback, mode_stat}, {1'b0, 1'b0, 2'd0});
      else       chk("R6 confirm disagree", {spare_en, rollback, mode_stat}, {1'b0, 1'b1, 2'd3});
      cyc();
      chk("R6 back to duplex", {rollback, mode_stat}, 0);
    end else begin
      chk("R5 reserve released", {spare_en, mode_stat}, 0);
    end
  endtask

  // one recovery episode: nc clean checkpoints, a mismatch, then an outcome
  task automatic episode(int nc, int kind, bit ext, bit agree, string tg);
    logic [W-1:0] va, vb, vs, v;
    int bad;
    bit perm;
    confirm_en = ext;
    for (int i = 0; i < nc; i++) begin
      v = $urandom;
      ckpt_all(v, v, 0, 1'b0);
      chk("R2 clean checkpoint", {spare_en, spare_load, mode_stat}, 0);
      model_clean();
    end
    va = $urandom;
    vb = va ^ (32'h1 << ($urandom % 32));
    ckpt_all(va, vb, 0, 1'b0);
    m_clean = 0;
    chk("R3 mismatch reaction", {spare_en, spare_load, mode_stat}, {1'b1, 1'b1, 2'd1});
    cyc();
    chk("R3 load is a pulse", {spare_en, spare_load}, {1'b1, 1'b0});
    repeat ($urandom % 3) cyc();
    vs = (kind == 0) ? va : (kind == 1) ? vb : neither(va, vb);
    bad = arb(va, vb, vs);
    sig_s = vs; sig_s_vld = 1'b1; cyc(); sig_s_vld = 1'b0;
    if (bad == 2) begin
      chk("R7 double failure", {rollback, spare_en, mode_stat}, {1'b1, 1'b0, 2'd3});
      cyc();
      chk("R7 after rollback", {rollback, mode_stat}, 0);
      return;
    end
    perm = (m_cnt[bad == 0 ? 1 : 0] != 0);
    if (m_cnt[bad == 0 ? 1 : 0] != 3) m_cnt[bad == 0 ? 1 : 0]++;
    if (perm) begin
      chk({tg, " swap issued"}, {copy_a2b, copy_b2a, swap_a, swap_b},
          {2'b00, bad == 1, bad == 0});
      cyc();
      chk("R8 swap held", {swap_a, swap_b}, {bad == 1, bad == 0});
      xfer_done = 1'b1; cyc(); xfer_done = 1'b0;
      chk("R8 spared state", {swap_a, swap_b, spare_en, mode_stat}, {3'b001, 2'd2});
      v = $urandom;
      if (bad == 0) ckpt_all(v, ~v, v, 1'b1); else ckpt_all(~v, v, v, 1'b1);
      chk("R11 spared agree", {rollback, mode_stat}, {1'b0, 2'd2});
      if (bad == 0) ckpt_all(v, v, ~v, 1'b1); else ckpt_all(v, v, ~v, 1'b1);
      chk("R11 spared disagree", {rollback, mode_stat}, {1'b1, 2'd3});
      cyc();
      chk("R11 stays spared", {rollback, spare_en, mode_stat}, {1'b0, 1'b1, 2'd2});
      do_reset();
    end else begin
      chk({tg, " copy issued"}, {copy_a2b, copy_b2a, swap_a, swap_b},
          {bad == 0, bad == 1, 2'b00});
      repeat ($urandom % 3) begin
        cyc();
        chk("R4 copy held", {copy_a2b, copy_b2a}, {bad == 0, bad == 1});
      end
      finish_copy(ext, agree);
    end
  endtask

  initial begin
    rst = 1'b1; ckpt = 1'b0; confirm_en = 1'b0; xfer_done = 1'b0;
    sig_a = '0; sig_b = '0; sig_s = '0;
    sig_a_vld = 1'b0; sig_b_vld = 1'b0; sig_s_vld = 1'b0;
    void'($urandom(32'd1234));
    cyc(); cyc();
    do_reset();

    // R12: held signatures used by a strobe-less checkpoint
    sig_a = 32'h1111; sig_a_vld = 1'b1; cyc(); sig_a_vld = 1'b0;
    sig_b = 32'h1111; sig_b_vld = 1'b1; cyc(); sig_b_vld = 1'b0;
    sig_a = 32'h5; sig_b = 32'h6; ckpt = 1'b1; cyc(); ckpt = 1'b0;
    chk("R12 held equal values", {spare_en, spare_load}, 0);
    sig_b = 32'h2222; sig_b_vld = 1'b1; cyc(); sig_b_vld = 1'b0;
    sig_a = 32'h7; sig_b = 32'h7; ckpt = 1'b1; cyc(); ckpt = 1'b0;
    chk("R12 held unequal values", {spare_en, spare_load}, 2'b11);
    do_reset();

    // R10: checkpoint during a copy is kept pending
    confirm_en = 1'b0;
    ckpt_all(32'hA0, 32'hB0, 0, 1'b0);
    cyc();
    sig_s = 32'hA0; sig_s_vld = 1'b1; cyc(); sig_s_vld = 1'b0;
    chk("R4 B faulty copy", {copy_a2b, copy_b2a}, 2'b10);
    ckpt_all(32'hC1, 32'hC2, 0, 1'b0);
    chk("R10 no evaluation during copy", {copy_a2b, spare_load}, 2'b10);
    xfer_done = 1'b1; cyc(); xfer_done = 1'b0;
    chk("R10 copy completes", {copy_a2b, spare_en, mode_stat}, 0);
    cyc();
    chk("R10 pending checkpoint evaluated", {spare_en, spare_load, mode_stat}, {2'b11, 2'd1});
    cyc();
    sig_s = 32'hC1; sig_s_vld = 1'b1; cyc(); sig_s_vld = 1'b0;
    chk("R8 repeat B fault swaps", {swap_b, copy_a2b}, 2'b10);
    xfer_done = 1'b1; cyc(); xfer_done = 1'b0;
    chk("R8 spared", mode_stat, 2'd2);
    do_reset();

    // R9: boundary of the clean-checkpoint limit
    episode(0, 0, 1'b0, 1'b1, "R4");
    episode(LIM - 1, 0, 1'b0, 1'b1, "R9 below limit");
    episode(0, 1, 1'b0, 1'b1, "R1 counts cleared");
    episode(LIM, 1, 1'b0, 1'b1, "R9 at limit");
    // R6 both outcomes, R7 directed
    episode(0, 0, 1'b1, 1'b1, "R4");
    episode(LIM, 1, 1'b1, 1'b0, "R4");
    episode(1, 2, 1'b0, 1'b1, "R7");

    for (int e = 0; e < 80; e++) begin
      int k;
      k = ($urandom % 4 == 3) ? 2 : int'($urandom % 2);
      episode(int'($urandom % 5), k, 1'($urandom % 2), 1'($urandom % 2), "R8");
    end

    report();
    $finish;
  end
endmodule